// File: doc/BRIEF.md
# Per-Processor Interrupt Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending interrupt: a valid flag, a 10-bit ID and a 4-bit priority, where a lower number is more urgent. The block decides whether that candidate may interrupt the processor and raises a registered IRQ line when it may. A candidate qualifies only when all three of these hold: the interface is enabled, the candidate beats the programmable priority mask, and it beats the priority of whatever is already being serviced.

Software reaches the block over a simple single-cycle 32-bit register bus. Reading the acknowledge register claims the candidate. The read returns its ID, pulses an acknowledge strobe back to the distributor and pushes its priority onto an internal stack of active priorities. If nothing qualifies, the read returns the reserved spurious ID 1023. Writing the end-of-interrupt register retires the most recently acknowledged interrupt, pulses an EOI strobe carrying the written ID, and restores the previous running priority. This lets interrupts nest correctly.

Top module: `cpu_irq_port`

## Requirements
- R1: Bit 0 of the control word (byte offset 0x00) enables the interface and resets to 0. While it is clear, irqOut is low on the following cycle and acknowledge reads return the spurious ID.
- R2: A read of offset 0x08 with a qualifying candidate returns pendId in busRdata bits 9:0 in the same cycle, with all other bits 0. In that same cycle ackPulse is high and ackId equals pendId.
- R3: A read of offset 0x08 with no qualifying candidate returns 1023 (all ones in bits 9:0), gives no ackPulse and leaves the running priority unchanged.
- R4: A write to offset 0x0C while an interrupt is active pulses eoiPulse in that cycle, with eoiId equal to busWdata bits 9:0. It removes the most recently acknowledged priority, so the running priority returns to the level it had before that acknowledge.
- R5: The mask word (offset 0x04) holds a 4-bit priority in bits 7:4, reads back in the same place, and resets to 0. A candidate qualifies only if its priority is strictly below the mask.
- R6: A read of offset 0x10 returns the running priority in bits 7:4. After an acknowledge, this is the acknowledged priority.
- R7: With no interrupt active, the running priority reads 0xF0.
- R8: A candidate qualifies only if its priority is strictly below the running priority. An equal priority neither preempts nor is acknowledged.
- R9: An EOI write with no active interrupt is ignored: eoiPulse stays low and the running priority stays 0xF0.
- R10: irqOut is registered. It is high exactly in the cycle after a cycle in which a valid candidate qualified.
- R11: Reads of unmapped offsets and of the EOI offset return 0, and a write to the acknowledge offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| pendValid | input | 1 | Distributor offers a candidate |
| pendId | input | 10 | Candidate interrupt ID |
| pendPrio | input | 4 | Candidate priority, 0 most urgent |
| ackPulse | output | 1 | Candidate claimed this cycle |
| ackId | output | 10 | ID claimed, valid with ackPulse |
| eoiPulse | output | 1 | Active interrupt retired this cycle |
| eoiId | output | 10 | ID retired, valid with eoiPulse |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check four things:
- the enable gate on the IRQ line;
- that every acknowledge carries the offered ID and beats both the mask and the running level;
- that spurious reads never pulse the distributor;
- that an idle stack reads the idle level, and that EOI never fires on an empty stack.

Two behaviours only the bench's scenarios can show. The first is the ordering of the stack across deep nesting: fifteen strictly rising urgencies are acknowledged and then unwound one at a time. The second is the exact cycle in which a mask or enable change reaches irqOut.

// File: rtl/cpu_irq_pkg.sv
`timescale 1ns/1ps
package cpu_irq_pkg;
  // word offsets (byte address bits 4:2)
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_MASK = 3'd1;
  localparam logic [2:0] OFS_ACK  = 3'd2;
  localparam logic [2:0] OFS_EOI  = 3'd3;
  localparam logic [2:0] OFS_RUN  = 3'd4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_MASK, SEL_ACK, SEL_RUN
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   wrCtrl;
    logic   wrMask;
    logic   push;
    logic   pop;
    rdSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/cpu_irq_ctl.sv
`timescale 1ns/1ps
module cpu_irq_ctl
  import cpu_irq_pkg::*;
(
  input  logic       busSel,
  input  logic       busWrite,
  input  logic [4:0] busAddr,
  input  logic       qualify,
  input  logic       stackEmpty,
  output ctlStrobe_t strb,
  output logic       ackPulse,
  output logic       eoiPulse
);
  logic [2:0] word;
  logic rdReq, wrReq;
  logic unusedAddr;

  assign word       = busAddr[4:2];
  assign unusedAddr = ^busAddr[1:0];
  assign rdReq      = busSel && !busWrite;
  assign wrReq      = busSel && busWrite;

  always_comb begin
    strb.wrCtrl = wrReq && (word == OFS_CTRL);
    strb.wrMask = wrReq && (word == OFS_MASK);
    strb.push   = rdReq && (word == OFS_ACK) && qualify;
    strb.pop    = wrReq && (word == OFS_EOI) && !stackEmpty;
    strb.rdSel  = SEL_NONE;
    if (rdReq) begin
      case (word)
        OFS_CTRL: strb.rdSel = SEL_CTRL;
        OFS_MASK: strb.rdSel = SEL_MASK;
        OFS_ACK:  strb.rdSel = SEL_ACK;
        OFS_RUN:  strb.rdSel = SEL_RUN;
        default:  strb.rdSel = SEL_NONE;
      endcase
    end
  end

  assign ackPulse = strb.push;
  assign eoiPulse = strb.pop;
endmodule

// File: rtl/cpu_irq_dp.sv
`timescale 1ns/1ps
module cpu_irq_dp
  import cpu_irq_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [31:0]       busWdata,
  input  logic              pendValid,
  input  logic [ID_W-1:0]   pendId,
  input  logic [PRIO_W-1:0] pendPrio,
  output logic [31:0]       busRdata,
  output logic              qualify,
  output logic              stackEmpty,
  output logic [ID_W-1:0]   ackId,
  output logic [ID_W-1:0]   eoiId,
  output logic              irqOut,
  output logic              ctrlEn,
  output logic [PRIO_W-1:0] maskPrio,
  output logic [PRIO_W-1:0] runPrio
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ID_W-1:0] SPURIOUS = {ID_W{1'b1}};

  logic [PRIO_W-1:0] stk [DEPTH];
  logic [CNT_W-1:0]  depthCnt;
  logic [IDX_W-1:0]  topIdx;
  logic              stackFull;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata;
  assign stackEmpty  = (depthCnt == '0);
  assign stackFull   = (depthCnt == CNT_W'(DEPTH));
  assign topIdx      = IDX_W'(depthCnt - CNT_W'(1));
  assign runPrio     = stackEmpty ? {PRIO_W{1'b1}} : stk[topIdx];

  assign qualify = ctrlEn && pendValid && !stackFull &&
                   (pendPrio < maskPrio) && (pendPrio < runPrio);

  assign ackId = strb.push ? pendId : '0;
  assign eoiId = busWdata[ID_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      maskPrio <= '0;
      irqOut   <= 1'b0;
      depthCnt <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      if (strb.wrCtrl) ctrlEn <= busWdata[0];
      if (strb.wrMask) maskPrio <= busWdata[4 +: PRIO_W];
      irqOut <= qualify;
      if (strb.push) depthCnt <= depthCnt + CNT_W'(1);
      else if (strb.pop) depthCnt <= depthCnt - CNT_W'(1);
      for (int i = 0; i < DEPTH; i++)
        if (strb.push && depthCnt == CNT_W'(i)) stk[i] <= pendPrio;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CTRL: busRdata = {31'b0, ctrlEn};
      SEL_MASK: busRdata = 32'(maskPrio) << 4;
      SEL_ACK:  busRdata = strb.push ? 32'(pendId) : 32'(SPURIOUS);
      SEL_RUN:  busRdata = 32'(runPrio) << 4;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/cpu_irq_port.sv
`timescale 1ns/1ps
module cpu_irq_port
  import cpu_irq_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [4:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              pendValid,
  input  logic [ID_W-1:0]   pendId,
  input  logic [PRIO_W-1:0] pendPrio,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiPulse,
  output logic [ID_W-1:0]   eoiId,
  output logic              irqOut
);
  ctlStrobe_t        strb;
  logic              qualify, stackEmpty, ctrlEn;
  logic [PRIO_W-1:0] maskPrio, runPrio;

  cpu_irq_ctl ctl_i (
    .busSel, .busWrite, .busAddr, .qualify, .stackEmpty,
    .strb, .ackPulse, .eoiPulse
  );

  cpu_irq_dp #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) dp_i (
    .clk, .rstN, .strb, .busWdata, .pendValid, .pendId, .pendPrio,
    .busRdata, .qualify, .stackEmpty, .ackId, .eoiId, .irqOut,
    .ctrlEn, .maskPrio, .runPrio
  );
endmodule

// File: rtl/cpu_irq_chk.sv
`timescale 1ns/1ps
module cpu_irq_chk
  import cpu_irq_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [4:0]        busAddr,
  input logic [31:0]       busRdata,
  input logic              pendValid,
  input logic [ID_W-1:0]   pendId,
  input logic [PRIO_W-1:0] pendPrio,
  input logic              ackPulse,
  input logic [ID_W-1:0]   ackId,
  input logic              eoiPulse,
  input logic              irqOut,
  input logic              ctrlEn,
  input logic [PRIO_W-1:0] maskPrio,
  input logic [PRIO_W-1:0] runPrio,
  input logic              stackEmpty
);
  logic ackRead;
  assign ackRead = busSel && !busWrite && (busAddr[4:2] == OFS_ACK);

  p_irq_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> !irqOut);

  p_ack_id_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (busRdata[ID_W-1:0] == pendId) && (ackId == pendId));

  p_spurious_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && !ackPulse) |-> (busRdata[ID_W-1:0] == {ID_W{1'b1}}));

  p_push_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> (runPrio == $past(pendPrio)));

  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    stackEmpty |-> (runPrio == {PRIO_W{1'b1}}));

  p_preempt_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (pendPrio < runPrio) && (pendPrio < maskPrio) && pendValid);

  p_eoi_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    eoiPulse |-> !stackEmpty);

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(ctrlEn && pendValid && (pendPrio < maskPrio)));
endmodule

bind cpu_irq_port cpu_irq_chk #(.ID_W(ID_W), .PRIO_W(PRIO_W)) chk_i (.*);

// File: tb/cpu_irq_port_tb.sv
`timescale 1ns/1ps
module cpu_irq_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWrite;
  logic [4:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  logic        pendValid;
  logic [9:0]  pendId;
  logic [3:0]  pendPrio;
  logic        ackPulse, eoiPulse, irqOut;
  logic [9:0]  ackId, eoiId;

  always #2 clk = ~clk;

  cpu_irq_port dut_i (
    .clk, .rstN, .busSel, .busWrite, .busAddr, .busWdata, .busRdata,
    .pendValid, .pendId, .pendPrio, .ackPulse, .ackId, .eoiPulse, .eoiId,
    .irqOut
  );

  int nVec = 0, nBad = 0;
  bit mEn;
  int mMask;
  int mStack[$];
  bit mIrq;

  function automatic int mRun();
    return (mStack.size() == 0) ? 15 : mStack[$];
  endfunction

  function automatic bit mQual(bit pv, int pp);
    return mEn && pv && pp < mMask && pp < mRun() && mStack.size() < 16;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle with a distributor candidate; compare against the model
  task automatic step(string tag, bit sel, bit wr, int addr, int wdata,
                      bit pv, int pid, int pp);
    bit q, expAck, expEoi;
    logic [31:0] expRd;
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = addr[4:0]; busWdata = wdata;
    pendValid = pv; pendId = pid[9:0]; pendPrio = pp[3:0];
    #1;
    q = mQual(pv, pp);
    expAck = sel && !wr && addr == 8 && q;
    expEoi = sel && wr && addr == 12 && mStack.size() > 0;
    expRd = '0;
    if (sel && !wr) begin
      case (addr)
        0:  expRd = {31'b0, mEn};
        4:  expRd = 32'(mMask) << 4;
        8:  expRd = q ? 32'(pid) : 32'd1023;
        16: expRd = 32'(mRun()) << 4;
        default: expRd = '0;
      endcase
    end
    chk(tag, "busRdata", busRdata, expRd);
    chk(tag, "ackPulse", {31'b0, ackPulse}, {31'b0, expAck});
    chk(tag, "eoiPulse", {31'b0, eoiPulse}, {31'b0, expEoi});
    chk(tag, "irqOut",   {31'b0, irqOut},   {31'b0, mIrq});
    if (expAck) chk(tag, "ackId", {22'b0, ackId}, 32'(pid));
    if (expEoi) chk(tag, "eoiId", {22'b0, eoiId}, {22'b0, wdata[9:0]});
    @(posedge clk);
    mIrq = q;
    if (expAck) mStack.push_back(pp);
    if (expEoi) void'(mStack.pop_back());
    if (sel && wr && addr == 0) mEn = wdata[0];
    if (sel && wr && addr == 4) mMask = (wdata >> 4) & 15;
  endtask

  task automatic rd(string tag, int addr, bit pv, int pid, int pp);
    step(tag, 1, 0, addr, 0, pv, pid, pp);
  endtask
  task automatic wrr(string tag, int addr, int data, bit pv, int pid, int pp);
    step(tag, 1, 1, addr, data, pv, pid, pp);
  endtask
  task automatic idle(string tag, bit pv, int pid, int pp);
    step(tag, 0, 0, 0, 0, pv, pid, pp);
  endtask

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; busSel = 0; busWrite = 0; busAddr = '0; busWdata = '0;
    pendValid = 0; pendId = '0; pendPrio = '0;
    mEn = 0; mMask = 0; mIrq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // reset state
    rd("R1", 0, 0, 0, 0);
    rd("R5", 4, 0, 0, 0);
    rd("R7", 16, 0, 0, 0);

    // disabled interface: no IRQ, spurious acknowledge
    wrr("R5", 4, 32'hF0, 1, 12, 2);
    idle("R1", 1, 12, 2);
    idle("R1", 1, 12, 2);
    rd("R3", 8, 1, 12, 2);
    rd("R7", 16, 1, 12, 2);

    // enable and take a first interrupt
    wrr("R1", 0, 1, 1, 37, 5);
    idle("R10", 1, 37, 5);
    idle("R10", 1, 37, 5);
    rd("R2", 8, 1, 37, 5);
    rd("R6", 16, 0, 0, 0);

    // equal priority does not preempt
    idle("R8", 1, 100, 5);
    rd("R8", 8, 1, 100, 5);
    // a more urgent one nests
    idle("R8", 1, 200, 3);
    rd("R2", 8, 1, 200, 3);
    rd("R6", 16, 1, 300, 4);
    // unwind
    wrr("R4", 12, 200, 0, 0, 0);
    rd("R4", 16, 0, 0, 0);
    wrr("R4", 12, 37, 0, 0, 0);
    rd("R7", 16, 0, 0, 0);

    // EOI with nothing active is ignored
    wrr("R9", 12, 55, 0, 0, 0);
    rd("R9", 16, 0, 0, 0);

    // mask boundary
    wrr("R5", 4, 32'h40, 1, 9, 4);
    idle("R5", 1, 9, 4);
    idle("R5", 1, 9, 4);
    rd("R5", 8, 1, 9, 4);
    idle("R5", 1, 10, 3);
    idle("R5", 1, 10, 3);
    rd("R5", 4, 1, 10, 3);
    rd("R2", 8, 1, 10, 3);
    wrr("R4", 12, 10, 0, 0, 0);

    // unmapped reads and write to acknowledge offset
    rd("R11", 12, 1, 1, 1);
    rd("R11", 20, 1, 1, 1);
    wrr("R11", 8, 32'h3FF, 1, 1, 1);
    rd("R11", 16, 0, 0, 0);

    // deep nesting, fifteen levels
    wrr("R5", 4, 32'hF0, 0, 0, 0);
    for (int p = 14; p >= 0; p--) begin
      idle("R8", 1, 500 + p, p);
      rd("R2", 8, 1, 500 + p, p);
    end
    rd("R6", 16, 0, 0, 0);
    rd("R3", 8, 1, 999, 0);
    for (int k = 0; k < 15; k++) begin
      wrr("R4", 12, 500 + k, 0, 0, 0);
      rd("R4", 16, 0, 0, 0);
    end
    rd("R7", 16, 0, 0, 0);

    // disable while a candidate qualifies
    idle("R10", 1, 77, 1);
    idle("R10", 1, 77, 1);
    wrr("R1", 0, 0, 1, 77, 1);
    idle("R1", 1, 77, 1);
    idle("R1", 1, 77, 1);
    rd("R1", 8, 1, 77, 1);
    rd("R1", 0, 1, 77, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule